// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This block returns a coarse estimate of 1/sqrt(x) for an IEEE-754 operand, good to about eight bits. A mode input picks double or single precision. A single-precision operand is first widened exactly into the double-precision working form. It then goes through the same datapath, and the double result is narrowed back to single precision.

The datapath splits the operand into its fields and sorts it into one of four classes: normal, zero, infinity or NaN. A subnormal operand is normalised with a leading-zero count, and each place shifted lowers the working exponent by one. The parity of the working exponent and the top fraction bits form a 9-bit index. That index selects one of 384 eight-bit estimates in a table that is computed during elaboration. The result exponent is the halved, re-biased working exponent. An operand that arrives with its valid strobe gives a registered result one clock later. The result register keeps its value until the next valid operand.

Top module: `rsqrt_est`

## Requirements
- R1: A result and `outValid` appear on the clock edge after the edge that samples `inValid` high. When `inValid` is low, `outValid` is low on the next cycle and `result` keeps its previous value whatever the operand lines carry.
- R2: The sign bit of the result always equals the sign bit of the operand (bit 63 in double mode, bit 31 in single mode).
- R3: An infinite operand (exponent all ones, fraction zero) gives a zero carrying the operand sign.
- R4: A NaN operand is returned with its sign, exponent and payload intact, and with the top fraction bit (bit 51 in double, bit 22 in single) set to 1.
- R5: A zero operand gives an infinity carrying the operand sign.
- R6: For a normal operand with working exponent e, the result exponent is ((3068 - e) / 2) truncated and kept to 11 bits. Result fraction bits [51:44] hold the table entry and all lower fraction bits are zero. The index is 0x80 OR fraction[51:45] when e is odd, and 0x100 OR fraction[51:44] when e is even. For example, 1.0 gives 0x3FEFF00000000000 and 4.0 gives 0x3FDFF00000000000.
- R7: A double subnormal is shifted left until its fraction bit 51 is 1, with e starting at 0 and lowering by one per shift. One more shift then drops that bit before the index is formed. For example, 0x0008000000000000 gives 0x5FE6900000000000.
- R8: The entry for index i (128..511) uses a = 2i+1 when i < 256 and a = 2(i OR 1) otherwise. Let c be the smallest integer of at least 257 with a·c² ≥ 2^28. The entry is c >> 1 kept to 8 bits. Index 255 gives 0x6A, 256 gives 0x69 and 511 gives 0x00.
- R9: In single mode (`isSingle` = 1) only operand bits [31:0] are used. The working exponent of a normal operand is its exponent plus 896. A subnormal operand is normalised with e starting at 896. The narrowed result takes exponent minus 896 (all ones stays all ones, zero stays zero) and fraction bits [51:29], and result bits [63:32] are zero. 0x41200000 gives 0x3EA18000.
- R10: While reset is asserted, `outValid` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| isSingle | input | 1 | 1 = single precision in bits [31:0], 0 = double precision |
| operand | input | 64 | Floating-point operand |
| outValid | output | 1 | Result register loaded on the previous edge |
| result | output | 64 | Estimate (single result in bits [31:0], upper bits zero) |

## Verification
Every result, special values included, is due exactly one edge after the edge that samples `inValid`. The bench drives each operand on a falling edge, drops the strobe on the next falling edge and reads `result` and `outValid` at that moment, half a period after the loading edge. The hold behaviour is read one further falling edge later, after the operand lines have been scrambled with the strobe low. Hand-worked vectors and a behavioural reference model, which searches the table rule by brute force, supply the expected values.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int DBL_W     = 64;
  localparam int EXP_W     = 11;
  localparam int FRAC_W    = 52;
  localparam int SGL_W     = 32;
  localparam int SEXP_W    = 8;
  localparam int SFRAC_W   = 23;
  localparam int IDX_W     = 9;
  localparam int EST_W     = 8;
  localparam int WEXP_W    = EXP_W + 2;
  localparam int LZ_W      = $clog2(FRAC_W + 1);
  localparam int TBL_LO    = 128;
  localparam int TBL_HI    = (1 << IDX_W) - 1;
  localparam int WIDEN_OFS = 896;
  localparam int RES_K     = 3068;
  localparam int NARROW_LO = FRAC_W - SFRAC_W;

  typedef enum logic [1:0] {
    CLS_NORMAL,
    CLS_ZERO,
    CLS_INF,
    CLS_NAN
  } opClass_t;

  typedef struct packed {
    logic captureEn;
    logic singleMode;
  } ctrlStrobe_t;

  // Estimate for one table index: bisection for the smallest c >= 257
  // with a*c*c >= 2^28, then c halved.
  function automatic logic [EST_W-1:0] tableEntry(input int idx);
    longint a;
    longint lo;
    longint hi;
    longint mid;
    longint lim;
    lim = longint'(1) << 28;
    a   = (idx < 256) ? longint'(2 * idx + 1) : longint'(2 * (idx | 1));
    lo  = 257;
    hi  = 2048;
    while (lo < hi) begin
      mid = (lo + hi) / 2;
      if (a * mid * mid >= lim) hi = mid;
      else lo = mid + 1;
    end
    return lo[EST_W:1];
  endfunction

endpackage

// File: rtl/rsqrt_ctrl.sv
module rsqrt_ctrl
  import rsqrt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isSingle,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.captureEn  = inValid;
    strobe.singleMode = isSingle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

endmodule

// File: rtl/rsqrt_table.sv
module rsqrt_table
  import rsqrt_pkg::*;
(
  input  logic [IDX_W-1:0] tableIdx,
  output logic [EST_W-1:0] estimate
);

  logic [EST_W-1:0] romEntry [TBL_LO:TBL_HI];

  for (genvar gi = TBL_LO; gi <= TBL_HI; gi++) begin : g_rom
    assign romEntry[gi] = tableEntry(gi);
  end

  always_comb begin
    if (int'(tableIdx) >= TBL_LO) estimate = romEntry[tableIdx];
    else                          estimate = '0;
  end

endmodule

// File: rtl/rsqrt_datapath.sv
module rsqrt_datapath
  import rsqrt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DBL_W-1:0]  operand,
  output logic [DBL_W-1:0]  result
);

  localparam logic [EXP_W-1:0]  EXP_ONES  = '1;
  localparam logic [SEXP_W-1:0] SEXP_ONES = '1;
  localparam logic [EXP_W-1:0]  WIDEN_E   = EXP_W'(WIDEN_OFS);

  // widened operand
  logic              wSign;
  logic [EXP_W-1:0]  wExp;
  logic [FRAC_W-1:0] wFrac;
  logic [EXP_W-1:0]  subBase;

  always_comb begin
    if (strobe.singleMode) begin
      wSign   = operand[SGL_W-1];
      subBase = WIDEN_E;
      wFrac   = {operand[SFRAC_W-1:0], {NARROW_LO{1'b0}}};
      if (operand[SGL_W-2:SFRAC_W] == SEXP_ONES)
        wExp = EXP_ONES;
      else if (operand[SGL_W-2:SFRAC_W] == '0)
        wExp = '0;
      else
        wExp = EXP_W'(operand[SGL_W-2:SFRAC_W]) + WIDEN_E;
    end else begin
      wSign   = operand[DBL_W-1];
      subBase = '0;
      wExp    = operand[DBL_W-2:FRAC_W];
      wFrac   = operand[FRAC_W-1:0];
    end
  end

  opClass_t opClass;
  logic     isSub;

  always_comb begin
    isSub = 1'b0;
    if (wExp == EXP_ONES)
      opClass = (wFrac == '0) ? CLS_INF : CLS_NAN;
    else if (wExp == '0) begin
      opClass = (wFrac == '0) ? CLS_ZERO : CLS_NORMAL;
      isSub   = (wFrac != '0);
    end else
      opClass = CLS_NORMAL;
  end

  // leading-zero count of the fraction field
  logic [LZ_W-1:0] leadZeros;
  logic            seenOne;

  always_comb begin
    leadZeros = '0;
    seenOne   = 1'b0;
    for (int k = FRAC_W - 1; k >= 0; k--) begin
      if (!seenOne) begin
        if (wFrac[k]) seenOne = 1'b1;
        else          leadZeros = leadZeros + 1'b1;
      end
    end
  end

  logic signed [WEXP_W-1:0] workExp;
  logic [FRAC_W-1:0]        normFrac;

  always_comb begin
    if (isSub) begin
      workExp  = $signed(WEXP_W'(subBase)) - $signed(WEXP_W'(leadZeros));
      normFrac = wFrac << (LZ_W + 1)'(leadZeros + 1'b1);
    end else begin
      workExp  = $signed(WEXP_W'(wExp));
      normFrac = wFrac;
    end
  end

  logic [IDX_W-1:0] tableIdx;
  logic [EST_W-1:0] estimate;

  always_comb begin
    if (workExp[0]) tableIdx = {2'b01, normFrac[FRAC_W-1 -: EST_W-1]};
    else            tableIdx = {1'b1,  normFrac[FRAC_W-1 -: EST_W]};
  end

  rsqrt_table u_table (
    .tableIdx (tableIdx),
    .estimate (estimate)
  );

  logic signed [WEXP_W:0] resDiff;
  logic [EXP_W-1:0]       resExp;

  always_comb begin
    resDiff = $signed((WEXP_W + 1)'(RES_K)) - $signed({workExp[WEXP_W-1], workExp});
    resExp  = resDiff[EXP_W:1];
  end

  logic [DBL_W-1:0] dblRes;

  always_comb begin
    unique case (opClass)
      CLS_INF:  dblRes = {wSign, {(DBL_W-1){1'b0}}};
      CLS_ZERO: dblRes = {wSign, EXP_ONES, {FRAC_W{1'b0}}};
      CLS_NAN:  dblRes = {wSign, wExp, 1'b1, wFrac[FRAC_W-2:0]};
      default:  dblRes = {wSign, resExp, estimate, {(FRAC_W-EST_W){1'b0}}};
    endcase
  end

  // narrowing to single precision
  logic [SEXP_W-1:0] nExp;
  logic [EXP_W-1:0]  nExpWide;
  logic [DBL_W-1:0]  nextRes;

  always_comb begin
    nExpWide = dblRes[DBL_W-2:FRAC_W] - WIDEN_E;
    if (dblRes[DBL_W-2:FRAC_W] == EXP_ONES)  nExp = SEXP_ONES;
    else if (dblRes[DBL_W-2:FRAC_W] == '0)   nExp = '0;
    else                                     nExp = nExpWide[SEXP_W-1:0];
    if (strobe.singleMode)
      nextRes = {{(DBL_W-SGL_W){1'b0}}, dblRes[DBL_W-1], nExp,
                 dblRes[FRAC_W-1:NARROW_LO]};
    else
      nextRes = dblRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 result <= '0;
    else if (strobe.captureEn) result <= nextRes;
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureEn |=> $stable(result));

  assert_sign_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureEn |=> (($past(strobe.singleMode) ? result[SGL_W-1] : result[DBL_W-1])
                          == ($past(strobe.singleMode) ? $past(operand[SGL_W-1])
                                                       : $past(operand[DBL_W-1]))));

  assert_inf_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureEn && !strobe.singleMode && operand[DBL_W-2:FRAC_W] == EXP_ONES
     && operand[FRAC_W-1:0] == '0) |=> result[DBL_W-2:0] == '0);

  assert_nan_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureEn && !strobe.singleMode && operand[DBL_W-2:FRAC_W] == EXP_ONES
     && operand[FRAC_W-1:0] != '0) |=> (result[FRAC_W-1] && result[DBL_W-2:FRAC_W] == EXP_ONES));

  assert_zero_inf_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureEn && !strobe.singleMode && operand[DBL_W-2:0] == '0)
    |=> (result[DBL_W-2:FRAC_W] == EXP_ONES && result[FRAC_W-1:0] == '0));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureEn && strobe.singleMode) |=> result[DBL_W-1:SGL_W] == '0);

endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             isSingle,
  input  logic [DBL_W-1:0] operand,
  output logic             outValid,
  output logic [DBL_W-1:0] result
);

  ctrlStrobe_t strobe;

  rsqrt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .isSingle (isSingle),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rsqrt_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operand (operand),
    .result  (result)
  );

endmodule

// File: tb/test_rsqrt_est.sv
module test_rsqrt_est;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        isSingle = 1'b0;
  logic [63:0] operand = '0;
  logic        outValid;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rsqrt_est i_rsqrt_est (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .isSingle (isSingle),
    .operand  (operand),
    .outValid (outValid),
    .result   (result)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model, written from the requirements
  function automatic logic [7:0] refEntry(input int idx);
    longint a;
    longint b;
    a = (idx < 256) ? longint'(2 * idx + 1) : longint'(2 * (idx | 1));
    b = 256;
    while (a * (b + 1) * (b + 1) < (longint'(1) << 28)) b++;
    return 8'(((b + 1) >> 1) & 255);
  endfunction

  function automatic logic [63:0] refDouble(input logic [63:0] x);
    longint e;
    logic [51:0] f;
    int idx;
    longint re;
    e = longint'(x[62:52]);
    f = x[51:0];
    if (e == 2047) begin
      if (f == 0) return {x[63], 63'b0};
      return x | 64'h0008_0000_0000_0000;
    end
    if (e == 0) begin
      if (f == 0) return {x[63], 11'h7FF, 52'b0};
      while (!f[51]) begin f = f << 1; e = e - 1; end
      f = f << 1;
    end
    if (e[0]) idx = 128 + int'(f[51:45]);
    else      idx = 256 + int'(f[51:44]);
    re = (3068 - e) / 2;
    return {x[63], re[10:0], refEntry(idx), 44'b0};
  endfunction

  function automatic logic [63:0] refSingle(input logic [31:0] s);
    logic [63:0] d;
    logic [63:0] r;
    logic [23:0] m;
    longint e;
    logic [7:0] se;
    if (s[30:23] == 8'hFF)      d = {s[31], 11'h7FF, s[22:0], 29'b0};
    else if (s[30:0] == 0)      d = {s[31], 63'b0};
    else if (s[30:23] == 0) begin
      m = {1'b0, s[22:0]};
      e = -126;
      while (!m[23]) begin m = m << 1; e = e - 1; end
      e = e + 1023;
      d = {s[31], e[10:0], m[22:0], 29'b0};
    end else begin
      e = longint'(s[30:23]) + 896;
      d = {s[31], e[10:0], s[22:0], 29'b0};
    end
    r = refDouble(d);
    if (r[62:52] == 11'h7FF) se = 8'hFF;
    else if (r[62:52] == 0)  se = 8'h00;
    else begin e = longint'(r[62:52]) - 896; se = e[7:0]; end
    return {32'b0, r[63], se, r[51:29]};
  endfunction

  task automatic runOp(input logic sgl, input logic [63:0] op,
                       output logic [63:0] got, output logic gotValid);
    @(negedge clk);
    inValid  = 1'b1;
    isSingle = sgl;
    operand  = op;
    @(negedge clk);
    inValid  = 1'b0;
    got      = result;
    gotValid = outValid;
  endtask

  typedef struct packed {
    logic [15:0] tag;
    logic        sgl;
    logic [63:0] op;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{"R9", 1'b1, 64'h0000_0000_4120_0000, 64'h0000_0000_3EA1_8000},
    '{"R6", 1'b0, 64'h4010_0000_0000_0000, 64'h3FDF_F000_0000_0000},
    '{"R6", 1'b0, 64'h3FF0_0000_0000_0000, 64'h3FEF_F000_0000_0000},
    '{"R3", 1'b0, 64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000},
    '{"R3", 1'b0, 64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000},
    '{"R5", 1'b0, 64'h0000_0000_0000_0000, 64'h7FF0_0000_0000_0000},
    '{"R5", 1'b0, 64'h8000_0000_0000_0000, 64'hFFF0_0000_0000_0000},
    '{"R4", 1'b0, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001},
    '{"R4", 1'b0, 64'hFFF8_0000_0000_0123, 64'hFFF8_0000_0000_0123},
    '{"R7", 1'b0, 64'h0008_0000_0000_0000, 64'h5FE6_9000_0000_0000},
    '{"R9", 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_7F80_0000},
    '{"R9", 1'b1, 64'h0000_0000_FF80_0000, 64'h0000_0000_8000_0000},
    '{"R4", 1'b1, 64'h0000_0000_7F80_0001, 64'h0000_0000_7FC0_0001},
    '{"R2", 1'b0, 64'hC010_0000_0000_0000, 64'hBFDF_F000_0000_0000},
    '{"R8", 1'b0, 64'h400F_F000_0000_0000, 64'h3FE0_0000_0000_0000},
    '{"R8", 1'b0, 64'h3FFF_E000_0000_0000, 64'h3FE6_A000_0000_0000},
    '{"R8", 1'b0, 64'h4000_0000_0000_0000, 64'h3FE6_9000_0000_0000},
    '{"R9", 1'b1, 64'hDEAD_BEEF_4120_0000, 64'h0000_0000_3EA1_8000}
  };

  localparam int NR = 18;
  localparam logic [64:0] REFOPS [NR] = '{
    {1'b0, 64'h3FB9_9999_9999_999A},
    {1'b0, 64'h7E37_E43C_8800_759C},
    {1'b0, 64'h0000_0000_0000_0001},
    {1'b0, 64'h000F_FFFF_FFFF_FFFF},
    {1'b0, 64'h0004_0000_0000_0000},
    {1'b0, 64'h8000_0000_0000_0003},
    {1'b0, 64'h7FEF_FFFF_FFFF_FFFF},
    {1'b0, 64'h0010_0000_0000_0000},
    {1'b0, 64'h4024_0000_0000_0000},
    {1'b1, 64'h0000_0000_3F80_0000},
    {1'b1, 64'h0000_0000_4000_0000},
    {1'b1, 64'h0000_0000_0000_0001},
    {1'b1, 64'h0000_0000_007F_FFFF},
    {1'b1, 64'h0000_0000_0040_0000},
    {1'b1, 64'h0000_0000_C120_0000},
    {1'b1, 64'h0000_0000_7F7F_FFFF},
    {1'b1, 64'h1234_5678_0080_0000},
    {1'b1, 64'h0000_0000_8000_0005}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [63:0] got;
    logic        gotValid;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    check("R10 outValid", {63'b0, outValid}, 64'd0);
    check("R10 result", result, 64'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      runOp(VECS[v].sgl, VECS[v].op, got, gotValid);
      check($sformatf("%s vector %0d", VECS[v].tag, v), got, VECS[v].exp);
      check("R1 outValid high", {63'b0, gotValid}, 64'd1);
    end

    for (int v = 0; v < NR; v++) begin
      runOp(REFOPS[v][64], REFOPS[v][63:0], got, gotValid);
      exp = REFOPS[v][64] ? refSingle(REFOPS[v][31:0]) : refDouble(REFOPS[v][63:0]);
      check($sformatf("R6/R7/R9 reference %0d", v), got, exp);
    end

    // R1: operand lines changed with the strobe low must not reach result
    runOp(1'b0, 64'h3FF0_0000_0000_0000, got, gotValid);
    operand  = 64'h7FF0_0000_0000_0000;
    isSingle = 1'b1;
    @(negedge clk);
    check("R1 hold result", result, 64'h3FEF_F000_0000_0000);
    check("R1 outValid low", {63'b0, outValid}, 64'd0);

    // R1: back-to-back operands, one result per edge
    @(negedge clk);
    inValid = 1'b1; isSingle = 1'b0; operand = 64'h4010_0000_0000_0000;
    @(negedge clk);
    check("R1 back-to-back first", result, 64'h3FDF_F000_0000_0000);
    operand = 64'hFFF0_0000_0000_0000;
    @(negedge clk);
    inValid = 1'b0;
    check("R1 back-to-back second", result, 64'h8000_0000_0000_0000);

    // R8: every table entry, probed through normal doubles
    for (int i = 128; i < 512; i++) begin
      logic [63:0] op;
      if (i < 256) op = {1'b0, 11'd1023, i[6:0], 45'b0};
      else         op = {1'b0, 11'd1024, i[7:0], 44'b0};
      runOp(1'b0, op, got, gotValid);
      check($sformatf("R8 entry %0d", i), {56'b0, got[51:44]}, {56'b0, refEntry(i)});
    end

    // R10: reset clears the result register
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R10 result after reset", result, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule